// File: doc/BRIEF.md
# Paged Presence-Detect EEPROM Two-Wire Target

This block is the target side of a two-wire serial bus (clock plus open-drain data) that stands in for the configuration EEPROM on a memory module. A bus controller reaches a 512-byte store through it. The store is seen as two pages of 256 bytes, and each page holds two protection blocks of 128 bytes. The target answers at one storage address, which it builds from a fixed memory type prefix and the three slot strap pins. It also answers a few fixed command addresses that do not depend on the straps. These commands select the active page and set or clear write protection.

The data line is observed through `sdaIn`, which is the resolved wire level. The target pulls the line low by asserting `sdaPullLow`. Bus inputs are synchronised to the block clock, and the target changes its pull-down only while the bus clock is low. A preload port writes bytes straight into the store, so a test environment can fill it before traffic starts. The address on this port is the flat 9-bit index {page, offset}.

Top module: `spdTarget`

## Requirements
- R1: After reset the active page is 0, all four blocks are unprotected and `sdaPullLow` is low.
- R2: A device-select byte is acknowledged for storage access only when its upper seven bits equal {1010, saStrap}. Any other address in the 1010 range is not acknowledged and leaves the store unchanged. Bit 0 of the device-select byte is the direction: 0 for write, 1 for read.
- R3: A storage write is device-select, then a byte offset, then data bytes. Each data byte goes to {page, offset}, and the offset then increments. The offset wraps from 0xFF to 0x00 and stays inside the active page.
- R4: A device-select with read direction returns bytes starting at the current offset, and the offset increments after each byte. A repeated START after an offset byte gives a random read. After the controller does not acknowledge a byte, the target releases the data line and stays released.
- R5: An acknowledged write to address 0x36 makes page 0 active, and one to 0x37 makes page 1 active, whatever the strap values. Any bytes that follow the command are not acknowledged.
- R6: A write to address 0x30+n (n = 0..3) protects block n, where block = {page bit, offset bit 7}. A write to 0x35 unprotects all blocks. Both commands are acknowledged and take effect only while `saHighVolt` is high. Without it they are not acknowledged and nothing changes.
- R7: A data byte aimed at a protected block is not acknowledged and the stored byte is left unchanged. The offset still advances by one, which a following current-offset read shows.
- R8: A STOP or START seen in the middle of a byte abandons the transfer without changing the store. After a START the target decodes a fresh device-select. Both conditions are recognised only while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Resolved bus data level |
| sdaPullLow | output | 1 | High pulls the data line low |
| saStrap | input | 3 | Slot strap pins, the low address bits |
| saHighVolt | input | 1 | High-voltage qualifier on strap 0, which enables protection commands |
| preloadEn | input | 1 | Direct store write strobe |
| preloadAddr | input | 9 | Flat store index {page, offset} for preload |
| preloadData | input | 8 | Preload byte |

## Verification
The table walk sends single-byte writes, random reads and bare command transfers. It mixes matching and foreign storage addresses, both pages, and protection commands with and without the qualifier. Each read-back tells a stored write apart from a refused one, and one page from the other. Directed sequences cover the remaining cases:
- a multi-byte write across offset 0xFF, which separates in-page wrap from a carry into the next page;
- a four-byte read across a block edge, which exposes offset stepping and bus release;
- a current-offset read after a refused byte, which shows the offset advance;
- transfers cut by STOP or START mid-byte, which must leave the store untouched.

// File: rtl/spdPkg.sv
package spdPkg;
  localparam int PAGE_BYTES  = 256;
  localparam int PAGE_COUNT  = 2;
  localparam int BLOCK_BYTES = 128;
  localparam int OFF_W       = $clog2(PAGE_BYTES);
  localparam int PAGE_W      = $clog2(PAGE_COUNT);
  localparam int MEM_DEPTH   = PAGE_COUNT * PAGE_BYTES;
  localparam int MEM_AW      = PAGE_W + OFF_W;
  localparam int BLOCK_COUNT = MEM_DEPTH / BLOCK_BYTES;
  localparam int BLK_W       = $clog2(BLOCK_COUNT);

  localparam logic [3:0] MEM_PREFIX = 4'b1010;
  localparam logic [3:0] CMD_PREFIX = 4'b0110;
  localparam logic [2:0] CODE_UNPROT = 3'd5;
  localparam logic [2:0] CODE_PAGE0  = 3'd6;
  localparam logic [2:0] CODE_PAGE1  = 3'd7;

  typedef struct packed {
    logic              setOff;
    logic              wrByte;
    logic              advance;
    logic              pageLoad;
    logic [PAGE_W-1:0] pageVal;
    logic              protSet;
    logic              protClr;
    logic [BLK_W-1:0]  protIdx;
    logic [7:0]        data;
  } dpCtl_t;
endpackage

// File: rtl/spdArray.sv
module spdArray
  import spdPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic                   preloadEn,
  input  logic [MEM_AW-1:0]      preloadAddr,
  input  logic [7:0]             preloadData,
  output logic [7:0]             rdData,
  output logic [BLOCK_COUNT-1:0] protMask,
  output logic [BLK_W-1:0]       curBlk
);
  logic [7:0]        store [MEM_DEPTH];
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  offset;
  logic [MEM_AW-1:0] ptr;

  assign ptr    = {page, offset};
  assign rdData = store[ptr];
  assign curBlk = ptr[MEM_AW-1 -: BLK_W];

  always_ff @(posedge clk) begin
    if (preloadEn)       store[preloadAddr] <= preloadData;
    else if (ctl.wrByte) store[ptr] <= ctl.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page   <= '0;
      offset <= '0;
    end else begin
      if (ctl.setOff)                      offset <= ctl.data[OFF_W-1:0];
      else if (ctl.wrByte || ctl.advance)  offset <= offset + 1'b1;
      if (ctl.pageLoad)                    page <= ctl.pageVal;
    end
  end

  for (genvar b = 0; b < BLOCK_COUNT; b++) begin : g_prot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         protMask[b] <= 1'b0;
      else if (ctl.protClr)                              protMask[b] <= 1'b0;
      else if (ctl.protSet && ctl.protIdx == BLK_W'(b))  protMask[b] <= 1'b1;
    end
  end

  // R5
  page_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (page != $past(page)) |-> $past(ctl.pageLoad));

  // R7
  prot_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrByte |-> !protMask[curBlk]);
endmodule

// File: rtl/spdBusCtl.sv
module spdBusCtl
  import spdPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [2:0]             saStrap,
  input  logic                   saHighVolt,
  input  logic [7:0]             rdData,
  input  logic [BLOCK_COUNT-1:0] protMask,
  input  logic [BLK_W-1:0]       curBlk,
  output dpCtl_t                 ctl,
  output logic                   sdaPullLow
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} busState_t;
  typedef enum logic [1:0] {K_DEV, K_OFF, K_DATA, K_IGN} byteKind_t;

  logic [1:0] sclSy, sdaSy, hvSy;
  logic       sclS, sdaS, hvS, sclP, sdaP;
  logic       sclRise, sclFall, startC, stopC;

  busState_t  state;
  byteKind_t  kind;
  logic [7:0] rxSh, txSh;
  logic [2:0] bitCnt;
  logic       rxFull, goTx, mAck;

  logic [6:0] devAddr;
  logic       devRd, memHit, cmdSpace, pageHit, protHit, clrHit;
  logic [2:0] code;

  assign sclS = sclSy[1];
  assign sdaS = sdaSy[1];
  assign hvS  = hvSy[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= 2'b11;
      sdaSy <= 2'b11;
      hvSy  <= 2'b00;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSy <= {sclSy[0], sclIn};
      sdaSy <= {sdaSy[0], sdaIn};
      hvSy  <= {hvSy[0], saHighVolt};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclRise = sclS && !sclP;
  assign sclFall = !sclS && sclP;
  assign startC  = sclS && sclP && sdaP && !sdaS;
  assign stopC   = sclS && sclP && !sdaP && sdaS;

  always_comb begin
    devAddr  = rxSh[7:1];
    devRd    = rxSh[0];
    code     = devAddr[2:0];
    memHit   = (devAddr == {MEM_PREFIX, saStrap});
    cmdSpace = (devAddr[6:3] == CMD_PREFIX) && !devRd;
    pageHit  = cmdSpace && (code == CODE_PAGE0 || code == CODE_PAGE1);
    protHit  = cmdSpace && hvS && (int'(code) < BLOCK_COUNT);
    clrHit   = cmdSpace && hvS && (code == CODE_UNPROT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= K_DEV;
      rxSh       <= '0;
      txSh       <= '0;
      bitCnt     <= '0;
      rxFull     <= 1'b0;
      goTx       <= 1'b0;
      mAck       <= 1'b0;
      sdaPullLow <= 1'b0;
      ctl        <= '0;
    end else begin
      ctl <= '0;
      if (startC) begin
        state      <= ST_RX;
        kind       <= K_DEV;
        bitCnt     <= '0;
        rxFull     <= 1'b0;
        sdaPullLow <= 1'b0;
      end else if (stopC) begin
        state      <= ST_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              rxSh   <= {rxSh[6:0], sdaS};
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) rxFull <= 1'b1;
            end else if (sclFall && rxFull) begin
              rxFull <= 1'b0;
              bitCnt <= '0;
              goTx   <= 1'b0;
              case (kind)
                K_DEV: begin
                  if (memHit) begin
                    state      <= ST_ACK;
                    sdaPullLow <= 1'b1;
                    goTx       <= devRd;
                    kind       <= K_OFF;
                  end else if (pageHit || protHit || clrHit) begin
                    state        <= ST_ACK;
                    sdaPullLow   <= 1'b1;
                    kind         <= K_IGN;
                    ctl.pageLoad <= pageHit;
                    ctl.pageVal  <= code[PAGE_W-1:0];
                    ctl.protSet  <= protHit;
                    ctl.protIdx  <= code[BLK_W-1:0];
                    ctl.protClr  <= clrHit;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_OFF: begin
                  state      <= ST_ACK;
                  sdaPullLow <= 1'b1;
                  kind       <= K_DATA;
                  ctl.setOff <= 1'b1;
                  ctl.data   <= rxSh;
                end
                K_DATA: begin
                  if (protMask[curBlk]) begin
                    state       <= ST_IDLE;
                    ctl.advance <= 1'b1;
                  end else begin
                    state      <= ST_ACK;
                    sdaPullLow <= 1'b1;
                    ctl.wrByte <= 1'b1;
                    ctl.data   <= rxSh;
                  end
                end
                default: state <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (goTx) begin
                state       <= ST_TX;
                txSh        <= rdData;
                sdaPullLow  <= !rdData[7];
                ctl.advance <= 1'b1;
              end else begin
                state      <= ST_RX;
                sdaPullLow <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                state      <= ST_MACK;
                sdaPullLow <= 1'b0;
              end else begin
                bitCnt     <= bitCnt + 3'd1;
                txSh       <= {txSh[6:0], 1'b0};
                sdaPullLow <= !txSh[6];
              end
            end
          end
          ST_MACK: begin
            if (sclRise) begin
              mAck <= !sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                state       <= ST_TX;
                bitCnt      <= '0;
                txSh        <= rdData;
                sdaPullLow  <= !rdData[7];
                ctl.advance <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclP) |-> $stable(sdaPullLow));

  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sdaPullLow);

  // R6
  prot_hv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.protSet || ctl.protClr) |-> $past(hvS));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.setOff, ctl.wrByte, ctl.advance, ctl.pageLoad, ctl.protSet, ctl.protClr}));
endmodule

// File: rtl/spdTarget.sv
module spdTarget
  import spdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [2:0]        saStrap,
  input  logic              saHighVolt,
  input  logic              preloadEn,
  input  logic [MEM_AW-1:0] preloadAddr,
  input  logic [7:0]        preloadData
);
  dpCtl_t                 ctl;
  logic [7:0]             rdData;
  logic [BLOCK_COUNT-1:0] protMask;
  logic [BLK_W-1:0]       curBlk;

  spdBusCtl u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .saStrap(saStrap), .saHighVolt(saHighVolt),
    .rdData(rdData), .protMask(protMask), .curBlk(curBlk),
    .ctl(ctl), .sdaPullLow(sdaPullLow)
  );

  spdArray u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .rdData(rdData), .protMask(protMask), .curBlk(curBlk)
  );
endmodule

// File: tb/sim_spdTarget.sv
module sim_spdTarget;
  localparam int H = 8;
  localparam int Q = 2;
  localparam int NV = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaPullLow;
  logic [2:0] saStrap = 3'b011;
  logic       saHighVolt = 1'b0;
  logic       preloadEn = 1'b0;
  logic [8:0] preloadAddr = '0;
  logic [7:0] preloadData = '0;
  wire        sdaBus = sdaM & ~sdaPullLow;

  int  total = 0, bad = 0;
  bit  finished = 0;
  logic [7:0] rdBuf [4];

  spdTarget u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .saStrap(saStrap), .saHighVolt(saHighVolt),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData)
  );

  // vector: kind(0 write,1 read,2 cmd) hv dev off val expAck reqNo
  localparam logic [30:0] VECS [NV] = '{
    {2'd1,1'b0,7'h53,8'h10,8'h10,1'b1,4'd1}, // R1 page 0 after reset
    {2'd0,1'b0,7'h53,8'h20,8'hA5,1'b1,4'd3}, // R3
    {2'd1,1'b0,7'h53,8'h20,8'hA5,1'b1,4'd3}, // R3
    {2'd0,1'b0,7'h52,8'h20,8'h11,1'b0,4'd2}, // R2 foreign slot
    {2'd1,1'b0,7'h53,8'h20,8'hA5,1'b1,4'd2}, // R2 unchanged
    {2'd2,1'b0,7'h37,8'h00,8'h00,1'b1,4'd5}, // R5
    {2'd1,1'b0,7'h53,8'h10,8'hD3,1'b1,4'd5}, // R5 page 1 content
    {2'd0,1'b0,7'h53,8'h20,8'h3C,1'b1,4'd5}, // R5
    {2'd1,1'b0,7'h53,8'h20,8'h3C,1'b1,4'd5}, // R5
    {2'd2,1'b0,7'h36,8'h00,8'h00,1'b1,4'd5}, // R5
    {2'd1,1'b0,7'h53,8'h20,8'hA5,1'b1,4'd5}, // R5 page 0 intact
    {2'd2,1'b0,7'h30,8'h00,8'h00,1'b0,4'd6}, // R6 no qualifier
    {2'd0,1'b0,7'h53,8'h40,8'h77,1'b1,4'd6}, // R6
    {2'd1,1'b0,7'h53,8'h40,8'h77,1'b1,4'd6}, // R6
    {2'd2,1'b1,7'h30,8'h00,8'h00,1'b1,4'd6}, // R6 protect block 0
    {2'd0,1'b1,7'h53,8'h40,8'h99,1'b0,4'd7}, // R7
    {2'd1,1'b1,7'h53,8'h40,8'h77,1'b1,4'd7}, // R7 unchanged
    {2'd0,1'b1,7'h53,8'h80,8'h66,1'b1,4'd6}, // R6 block 1 open
    {2'd1,1'b1,7'h53,8'h80,8'h66,1'b1,4'd6}, // R6
    {2'd2,1'b0,7'h35,8'h00,8'h00,1'b0,4'd6}, // R6 clear refused
    {2'd0,1'b0,7'h53,8'h40,8'h12,1'b0,4'd6}, // R6 still protected
    {2'd2,1'b1,7'h35,8'h00,8'h00,1'b1,4'd6}, // R6 clear all
    {2'd0,1'b1,7'h53,8'h40,8'h12,1'b1,4'd6}, // R6
    {2'd1,1'b1,7'h53,8'h40,8'h12,1'b1,4'd6}, // R6
    {2'd2,1'b1,7'h33,8'h00,8'h00,1'b1,4'd6}, // R6 protect block 3
    {2'd2,1'b1,7'h37,8'h00,8'h00,1'b1,4'd5}, // R5
    {2'd0,1'b1,7'h53,8'h90,8'h55,1'b0,4'd7}, // R7 block 3
    {2'd0,1'b1,7'h53,8'h10,8'h55,1'b1,4'd6}, // R6 block 2 open
    {2'd1,1'b1,7'h53,8'h10,8'h55,1'b1,4'd6}, // R6
    {2'd1,1'b1,7'h53,8'h90,8'h53,1'b1,4'd7}, // R7 unchanged
    {2'd2,1'b1,7'h35,8'h00,8'h00,1'b1,4'd6}, // R6
    {2'd2,1'b1,7'h36,8'h00,8'h00,1'b1,4'd5}  // R5
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ ((a >= 256) ? 8'hC3 : 8'h00);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(H); sclM = 1'b1; tick(H); sdaM = 1'b0; tick(H); sclM = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(H); sclM = 1'b1; tick(H); sdaM = 1'b1; tick(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(H); sclM = 1'b1; tick(H); sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; tick(H); sclM = 1'b1; tick(H/2); ack = !sdaBus; tick(H/2); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    b = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H); sclM = 1'b1; tick(H/2); b = {b[6:0], sdaBus}; tick(H/2); sclM = 1'b0; tick(Q);
    end
    sdaM = !ackIt; tick(H); sclM = 1'b1; tick(H); sclM = 1'b0; tick(Q); sdaM = 1'b1;
  endtask

  task automatic xferCmd(input logic [6:0] dev, output logic ok);
    startCond(); sendByte({dev, 1'b0}, ok); stopCond();
  endtask

  task automatic xferWrite(input logic [6:0] dev, input logic [7:0] off, input logic [7:0] val, output logic ok);
    logic a0, a1, a2;
    a1 = 0; a2 = 0;
    startCond(); sendByte({dev, 1'b0}, a0);
    if (a0) begin sendByte(off, a1); sendByte(val, a2); end
    stopCond();
    ok = a0 & a1 & a2;
  endtask

  task automatic xferRead(input logic [6:0] dev, input logic [7:0] off, input int n, output logic ok);
    logic a0, a1, a2;
    startCond(); sendByte({dev, 1'b0}, a0); sendByte(off, a1);
    startCond(); sendByte({dev, 1'b1}, a2);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    stopCond();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] d;
    tick(2);
    for (int i = 0; i < 512; i++) begin
      preloadEn = 1'b1; preloadAddr = 9'(i); preloadData = pat(i); tick(1);
    end
    preloadEn = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(3);
    chk(sdaPullLow == 1'b0, "R1 line released after reset", 32'(sdaPullLow), 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] kd; logic hv; logic [6:0] dv; logic [7:0] of, vl; logic ea; logic [3:0] rq;
      {kd, hv, dv, of, vl, ea, rq} = VECS[v];
      saHighVolt = hv; tick(4);
      if (kd == 2'd0) begin
        xferWrite(dv, of, vl, ok);
        chk(ok == ea, $sformatf("R%0d vec %0d write ack", rq, v), 32'(ok), 32'(ea));
      end else if (kd == 2'd1) begin
        xferRead(dv, of, 1, ok);
        chk(ok == ea && rdBuf[0] == vl, $sformatf("R%0d vec %0d read", rq, v),
            {23'd0, ok, rdBuf[0]}, {23'd0, ea, vl});
      end else begin
        xferCmd(dv, ok);
        chk(ok == ea, $sformatf("R%0d vec %0d command ack", rq, v), 32'(ok), 32'(ea));
      end
    end
    saHighVolt = 1'b0; tick(4);

    // R2 and R5: other strap value
    saStrap = 3'b101; tick(4);
    xferCmd(7'h37, ok);
    chk(ok, "R5 page command ignores straps", 32'(ok), 1);
    xferWrite(7'h53, 8'h10, 8'hEE, ok);
    chk(!ok, "R2 old slot address refused", 32'(ok), 0);
    xferRead(7'h55, 8'h10, 1, ok);
    chk(ok && rdBuf[0] == 8'h55, "R2 new slot address reads page 1", 32'(rdBuf[0]), 32'h55);
    xferCmd(7'h36, ok);
    saStrap = 3'b011; tick(4);

    // R3 multi-byte write wrapping inside page 0
    startCond(); sendByte(8'hA6, a); sendByte(8'hFE, a);
    sendByte(8'hA1, a); sendByte(8'hA2, a); sendByte(8'hA3, a); stopCond();
    xferRead(7'h53, 8'hFE, 3, ok);
    chk(ok && rdBuf[0] == 8'hA1 && rdBuf[1] == 8'hA2 && rdBuf[2] == 8'hA3, "R3 wrap write and read",
        {8'd0, rdBuf[0], rdBuf[1], rdBuf[2]}, 32'hA1A2A3);
    xferCmd(7'h37, ok);
    xferRead(7'h53, 8'h00, 1, ok);
    chk(rdBuf[0] == 8'hC3, "R3 wrap kept out of page 1", 32'(rdBuf[0]), 32'hC3);
    xferCmd(7'h36, ok);

    // R4 sequential read across block edge then release
    xferRead(7'h53, 8'h7E, 4, ok);
    chk(ok && rdBuf[0] == 8'h7E && rdBuf[1] == 8'h7F && rdBuf[2] == 8'h66 && rdBuf[3] == 8'h81,
        "R4 sequential read", {rdBuf[0], rdBuf[1], rdBuf[2], rdBuf[3]}, 32'h7E7F6681);
    tick(10);
    chk(sdaPullLow == 1'b0, "R4 released after controller nack", 32'(sdaPullLow), 0);

    // R7 offset advances after refused byte
    saHighVolt = 1'b1; tick(4);
    xferCmd(7'h30, ok);
    xferWrite(7'h53, 8'h05, 8'hEE, ok);
    chk(!ok, "R7 protected byte refused", 32'(ok), 0);
    startCond(); sendByte(8'hA7, a); recvByte(1'b0, d); stopCond();
    chk(a && d == 8'h06, "R7 current read after refusal", 32'(d), 32'h06);
    xferCmd(7'h35, ok);
    saHighVolt = 1'b0; tick(4);

    // R8 STOP mid-byte
    startCond(); sendBits(8'hA6, 4); stopCond();
    tick(4);
    chk(sdaPullLow == 1'b0, "R8 idle after stop mid-byte", 32'(sdaPullLow), 0);
    startCond(); sendByte(8'hA6, a); sendByte(8'h30, a); sendBits(8'hFF, 4); stopCond();
    xferRead(7'h53, 8'h30, 1, ok);
    chk(ok && rdBuf[0] == 8'h30, "R8 cut data byte not stored", 32'(rdBuf[0]), 32'h30);
    // R8 START mid-byte restarts decoding
    startCond(); sendByte(8'hA6, a); sendBits(8'h12, 3);
    startCond(); sendByte(8'hA6, a); sendByte(8'h31, a); sendByte(8'h44, a); stopCond();
    xferRead(7'h53, 8'h31, 1, ok);
    chk(ok && rdBuf[0] == 8'h44, "R8 restart after start mid-byte", 32'(rdBuf[0]), 32'h44);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule